// File: doc/BRIEF.md
# Sign-Redundancy Normalization Counter

This block measures how many redundant sign bits a signed operand carries. The answer is the left-shift distance that moves the most significant bit that differs from the sign up to the position directly below the sign. Block floating-point datapaths use the count to choose a common exponent and to scale a group of samples before they are stored or multiplied. The shift itself is done elsewhere.

One input selects the operand width: 16 bits, taken from the low half of the operand bus, or the full 32 bits. A valid flag qualifies each operand. The operand is captured in an input register. The count is found by a halving search over the operand's magnitude and placed in an output register on the following clock. A negative operand is bit-inverted before it is searched, so a value and its one's complement give the same count. Two operands need fixed answers: zero returns 0, and minus one returns the width less one.

Top module: `sign_norm_unit`

## Requirements
- R1: `res_valid` is low in the cycle after a synchronous reset and otherwise equals `op_valid` delayed by exactly two clock edges. A reset in the middle of a stream clears both pipeline valids.
- R2: With `wide_sel`=0 (16-bit mode), a low half of 0x0000 gives a count of 0.
- R3: With `wide_sel`=0, a low half of 0xFFFF gives a count of 15.
- R4: With `wide_sel`=1 (32-bit mode), an operand of 0x00000000 gives a count of 0.
- R5: With `wide_sel`=1, an operand of 0xFFFFFFFF gives a count of 31.
- R6: In 16-bit mode, bits 31:16 of `op_data` do not affect the count.
- R7: A negative operand (sign bit 15 in 16-bit mode, bit 31 in 32-bit mode) gives the same count as its bitwise inverse.
- R8: For a positive operand, the count is the number of single-bit left shifts needed before the value reaches 0x4000 (16-bit mode) or 0x40000000 (32-bit mode). An operand whose top two bits are 01 therefore gives 0.
- R9: `norm_shift` keeps its value on every edge at which no captured operand is pending.
- R10: A count produced in 16-bit mode never exceeds 15.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| op_valid | input | 1 | Qualifies `op_data` and `wide_sel` in this cycle |
| wide_sel | input | 1 | 0 selects 16-bit mode (bits 15:0 used), 1 selects 32-bit mode |
| op_data | input | 32 | Signed operand |
| res_valid | output | 1 | `norm_shift` carries a new count |
| norm_shift | output | 5 | Count of redundant sign bits, unsigned, 0 to 31 |

## Verification
Two things can happen on the same edge. The input register takes a new operand while the output register takes the count of the operand captured one edge earlier, and those two operands may use different widths. The bench sends back-to-back valid operands with `wide_sel` toggling at random, mixes in idle gaps and one reset in mid-stream, and compares the port values on every cycle against a queue-free behavioural model. The model counts shifts in a loop. A width that leaks from one operand into its neighbour, or a count that moves during a gap, shows up as a mismatch on that cycle.

// File: rtl/signorm_pkg.sv
package signorm_pkg;

    typedef enum logic {
        MODE_NARROW = 1'b0,
        MODE_WIDE   = 1'b1
    } width_mode_e;

endpackage

// File: rtl/signorm_fold.sv
// Reduces an operand to the magnitude word that the search scans.
// The sign is folded away by inversion. A narrow magnitude is left
// aligned and padded below with ones so that its count stops at NARROW_W-1.
module signorm_fold
    import signorm_pkg::*;
#(
    parameter int WIDE_W   = 32,
    parameter int NARROW_W = 16
) (
    input  logic [WIDE_W-1:0] operand,
    input  width_mode_e       mode,
    output logic [WIDE_W-1:0] scan_vec,
    output logic              is_zero
);
    localparam int PAD_W = WIDE_W - NARROW_W;

    logic [NARROW_W-1:0] narrow_op;
    logic [NARROW_W-2:0] narrow_mag;
    logic [WIDE_W-2:0]   wide_mag;

    always_comb begin
        narrow_op  = operand[NARROW_W-1:0];
        narrow_mag = narrow_op[NARROW_W-1] ? ~narrow_op[NARROW_W-2:0]
                                           :  narrow_op[NARROW_W-2:0];
        wide_mag   = operand[WIDE_W-1] ? ~operand[WIDE_W-2:0]
                                       :  operand[WIDE_W-2:0];
        if (mode == MODE_WIDE) begin
            scan_vec = {wide_mag, 1'b1};
            is_zero  = (operand == '0);
        end else begin
            scan_vec = {narrow_mag, {(PAD_W + 1){1'b1}}};
            is_zero  = (narrow_op == '0);
        end
    end

endmodule

// File: rtl/signorm_search.sv
// Halving search for leading zeros. Each stage tests the upper half of
// the remaining window, records one result bit and shifts the window
// when that half is empty. The caller keeps bit 0 set, so the count stays
// below W.
module signorm_search #(
    parameter int W = 32
) (
    input  logic [W-1:0]         vec,
    output logic [$clog2(W)-1:0] count
);
    localparam int STAGES = $clog2(W);

    logic [W-1:0] window [STAGES+1];

    assign window[0] = vec;

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        localparam int HALF = W >> (s + 1);
        logic upper_empty;
        assign upper_empty     = (window[s][W-1 -: HALF] == '0);
        assign count[STAGES-1-s] = upper_empty;
        assign window[s+1]     = upper_empty ? (window[s] << HALF) : window[s];
    end

endmodule

// File: rtl/sign_norm_unit.sv
module sign_norm_unit
    import signorm_pkg::*;
#(
    parameter int WIDE_W   = 32,
    parameter int NARROW_W = 16
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       op_valid,
    input  logic                       wide_sel,
    input  logic [WIDE_W-1:0]          op_data,
    output logic                       res_valid,
    output logic [$clog2(WIDE_W)-1:0]  norm_shift
);
    localparam int CNT_W = $clog2(WIDE_W);

    typedef struct packed {
        logic              valid;
        logic              wide;
        logic [WIDE_W-1:0] operand;
    } cap_t;

    typedef struct packed {
        logic             valid;
        logic [CNT_W-1:0] amt;
    } res_t;

    typedef struct packed {
        cap_t cap;
        res_t res;
    } state_t;

    state_t state_d, state_q;

    logic [WIDE_W-1:0] scan_vec;
    logic              op_is_zero;
    logic [CNT_W-1:0]  search_cnt;

    signorm_fold #(
        .WIDE_W   (WIDE_W),
        .NARROW_W (NARROW_W)
    ) u_fold (
        .operand  (state_q.cap.operand),
        .mode     (width_mode_e'(state_q.cap.wide)),
        .scan_vec (scan_vec),
        .is_zero  (op_is_zero)
    );

    signorm_search #(
        .W (WIDE_W)
    ) u_search (
        .vec   (scan_vec),
        .count (search_cnt)
    );

    always_comb begin
        state_d           = state_q;
        state_d.cap.valid = op_valid;
        if (op_valid) begin
            state_d.cap.wide    = wide_sel;
            state_d.cap.operand = op_data;
        end
        state_d.res.valid = state_q.cap.valid;
        if (state_q.cap.valid) begin
            state_d.res.amt = op_is_zero ? '0 : search_cnt;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign res_valid  = state_q.res.valid;
    assign norm_shift = state_q.res.amt;

endmodule

// File: rtl/sign_norm_chk.sv
module sign_norm_chk #(
    parameter int WIDE_W   = 32,
    parameter int NARROW_W = 16
) (
    input logic                      clk,
    input logic                      rst,
    input logic                      op_valid,
    input logic                      s1_valid,
    input logic                      s1_wide,
    input logic [WIDE_W-1:0]         s1_operand,
    input logic                      res_valid,
    input logic [$clog2(WIDE_W)-1:0] norm_shift
);
    localparam int CNT_W = $clog2(WIDE_W);

    p_rst_clear_r1: assert property (@(posedge clk)
        rst |=> !res_valid);

    p_latency_r1: assert property (@(posedge clk) disable iff (rst)
        op_valid |=> ##1 res_valid);

    p_idle_r1: assert property (@(posedge clk) disable iff (rst)
        !op_valid |=> ##1 !res_valid);

    p_zero16_r2: assert property (@(posedge clk) disable iff (rst)
        (s1_valid && !s1_wide && s1_operand[NARROW_W-1:0] == '0)
        |=> norm_shift == '0);

    p_ones16_r3: assert property (@(posedge clk) disable iff (rst)
        (s1_valid && !s1_wide && s1_operand[NARROW_W-1:0] == '1)
        |=> norm_shift == CNT_W'(NARROW_W - 1));

    p_zero32_r4: assert property (@(posedge clk) disable iff (rst)
        (s1_valid && s1_wide && s1_operand == '0) |=> norm_shift == '0);

    p_ones32_r5: assert property (@(posedge clk) disable iff (rst)
        (s1_valid && s1_wide && s1_operand == '1)
        |=> norm_shift == CNT_W'(WIDE_W - 1));

    p_top_set_r8: assert property (@(posedge clk) disable iff (rst)
        (s1_valid && s1_wide && s1_operand[WIDE_W-1 -: 2] == 2'b01)
        |=> norm_shift == '0);

    p_hold_r9: assert property (@(posedge clk) disable iff (rst)
        !s1_valid |=> $stable(norm_shift));

    p_narrow_range_r10: assert property (@(posedge clk) disable iff (rst)
        (s1_valid && !s1_wide) |=> norm_shift <= CNT_W'(NARROW_W - 1));

endmodule

bind sign_norm_unit sign_norm_chk #(
    .WIDE_W   (WIDE_W),
    .NARROW_W (NARROW_W)
) u_chk (
    .clk        (clk),
    .rst        (rst),
    .op_valid   (op_valid),
    .s1_valid   (state_q.cap.valid),
    .s1_wide    (state_q.cap.wide),
    .s1_operand (state_q.cap.operand),
    .res_valid  (res_valid),
    .norm_shift (norm_shift)
);

// File: tb/sign_norm_unit_tb.sv
`timescale 1ns/1ps
module sign_norm_unit_tb;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        op_valid = 1'b0;
    logic        wide_sel = 1'b0;
    logic [31:0] op_data = '0;
    logic        res_valid;
    logic [4:0]  norm_shift;

    int tests = 0;
    int fails = 0;
    bit done  = 1'b0;

    always #5 clk = ~clk;

    sign_norm_unit u_dut (
        .clk        (clk),
        .rst        (rst),
        .op_valid   (op_valid),
        .wide_sel   (wide_sel),
        .op_data    (op_data),
        .res_valid  (res_valid),
        .norm_shift (norm_shift)
    );

    function automatic int ref_amt(bit w, logic [31:0] x);
        longint v;
        longint lim;
        int     n;
        if (!w) begin
            v = longint'($signed(x[15:0]));
            if (v == 0)  return 0;
            if (v == -1) return 15;
            lim = 64'sh4000;
        end else begin
            v = longint'($signed(x));
            if (v == 0)  return 0;
            if (v == -1) return 31;
            lim = 64'sh40000000;
        end
        if (v < 0) v = -v - 1;
        n = 0;
        while (v < lim) begin
            v = v <<< 1;
            n++;
        end
        return n;
    endfunction

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h at %0t", req, act, exp, $time);
        end
    endtask

    // Behavioural model, updated on every edge.
    bit        m_v1 = 0;
    bit        m_w1 = 0;
    bit [31:0] m_x1 = 0;
    bit        m_ov = 0;
    int        m_amt = 0;
    bit        started = 0;

    always @(posedge clk) begin
        started <= 1'b1;
        if (rst) begin
            m_v1  <= 0;
            m_w1  <= 0;
            m_x1  <= 0;
            m_ov  <= 0;
            m_amt <= 0;
        end else begin
            m_v1 <= op_valid;
            if (op_valid) begin
                m_w1 <= wide_sel;
                m_x1 <= op_data;
            end
            m_ov <= m_v1;
            if (m_v1) m_amt <= ref_amt(m_w1, m_x1);
        end
    end

    always @(negedge clk) begin
        if (started && !done) begin
            chk("R1 model valid", 32'(res_valid), 32'(m_ov));
            chk("R9 model count", 32'(norm_shift), 32'(m_amt));
        end
    end

    task automatic one_op(bit w, logic [31:0] x, int exp, string req);
        @(negedge clk);
        op_valid = 1'b1;
        wide_sel = w;
        op_data  = x;
        @(negedge clk);
        op_valid = 1'b0;
        op_data  = ~x;
        chk("R1 not yet valid", 32'(res_valid), 32'd0);
        @(negedge clk);
        chk("R1 valid after two edges", 32'(res_valid), 32'd1);
        chk(req, 32'(norm_shift), 32'(exp));
    endtask

    initial begin
        #(200000 * 10);
        if (!done) begin
            tests++;
            fails++;
            $display("FAIL watchdog: actual hung expected finish");
            done = 1'b1;
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        chk("R1 reset valid", 32'(res_valid), 32'd0);
        chk("R1 reset count", 32'(norm_shift), 32'd0);
        rst = 1'b0;

        one_op(1'b0, 32'h0000_0000, 0,  "R2 zero16");
        one_op(1'b0, 32'hABCD_0000, 0,  "R6 zero16 upper ignored");
        one_op(1'b0, 32'h0000_FFFF, 15, "R3 ones16");
        one_op(1'b0, 32'h1234_FFFF, 15, "R6 ones16 upper ignored");
        one_op(1'b1, 32'h0000_0000, 0,  "R4 zero32");
        one_op(1'b1, 32'hFFFF_FFFF, 31, "R5 ones32");
        one_op(1'b0, 32'h0000_0001, 14, "R8 one16");
        one_op(1'b0, 32'h0000_4000, 0,  "R8 top16");
        one_op(1'b0, 32'h0000_7FFF, 0,  "R8 max16");
        one_op(1'b0, 32'h0000_2000, 1,  "R8 shift1");
        one_op(1'b0, 32'hFFFF_2000, 1,  "R6 shift1 upper ignored");
        one_op(1'b1, 32'h0000_0001, 30, "R8 one32");
        one_op(1'b1, 32'h4000_0000, 0,  "R8 top32");
        one_op(1'b1, 32'h0000_8000, 15, "R8 mid32");
        one_op(1'b1, 32'h0001_0000, 14, "R8 half32");
        one_op(1'b0, 32'h0000_8000, 0,  "R7 min16");
        one_op(1'b0, 32'h0000_FFFE, 14, "R7 minus2 16");
        one_op(1'b1, 32'hFFFF_FFFE, 30, "R7 minus2 32");
        one_op(1'b1, 32'h8000_0000, 0,  "R7 min32");
        one_op(1'b1, 32'hFFFF_0000, 15, "R7 neg32");

        // R9: idle cycles with a moving operand bus leave the count unchanged
        for (int i = 0; i < 6; i++) begin
            @(negedge clk);
            op_data  = $urandom;
            wide_sel = ~wide_sel;
            chk("R9 hold", 32'(norm_shift), 32'd15);
        end

        // Streaming with toggled widths, gaps and one mid-stream reset
        for (int i = 0; i < 4000; i++) begin
            @(negedge clk);
            if (i == 2000) begin
                rst = 1'b1;
                op_valid = 1'b1;
            end else begin
                if (rst) rst = 1'b0;
                op_valid = ($urandom % 10) < 7;
            end
            wide_sel = $urandom % 2;
            case ($urandom % 4)
                0: op_data = $urandom;
                1: op_data = $urandom >> ($urandom % 32);
                2: op_data = ~($urandom >> ($urandom % 32));
                default: op_data = ($urandom % 2) ? 32'hFFFF_FFFF : 32'h0;
            endcase
            if (i == 2001) chk("R1 valid cleared by reset", 32'(res_valid), 32'd0);
            if (res_valid && u_dut.wide_sel !== 1'bx) begin
                if (norm_shift > 5'd31) chk("R10 range", 32'(norm_shift), 32'd31);
            end
        end
        @(negedge clk);
        op_valid = 1'b0;
        repeat (3) @(negedge clk);

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule